// File: doc/BRIEF.md
# Flash Embedded Operation Status Generator

This block sits beside the command decoder of a flash die model. It produces the status byte a host reads while an embedded program or erase runs. Each program or erase is modelled as a cycle counter instead of real cell physics. The block accepts start events from the decoder: a program carries its target sector, its data byte and the byte currently stored; a sector erase carries its sector; a chip erase carries nothing. It also accepts read strobes and a per-sector write-protection mask.

Sector erase commands first open an accumulation window. During the window, further sector erase commands can join the same erase. When the window runs out, the block raises an erase-start pulse together with the mask of sectors that will actually be erased. All durations are parameters given in clock cycles.

Top module: `flash_op_status`

## Requirements
- R1: After reset the block is idle, `busy_o` is 0, `erase_go_o` is 0 and `status_o` reads 8'h80.
- R2: Status bit 7 reads the complement of the programmed byte's bit 7 while a program runs, and its true value once the block is idle again. An unprotected program that clears bits only (`prog_data_i & ~cell_data_i` is zero) keeps `busy_o` high for exactly T_PROG cycles.
- R3: Status bit 6 inverts after every `rd_i` strobe while `busy_o` is high, including in the erase window. It holds its value while idle.
- R4: A program that tries to raise any bit from 0 to 1 sets status bit 5 after T_PLIM busy cycles. The block then stays busy with bit 5 set until `reset_cmd_i`; other commands are ignored meanwhile.
- R5: A sector erase command from idle opens a window of T_WIN cycles with status bit 3 at 0 and bit 7 at 0. Each further sector erase command in the window adds its sector and restarts the full window.
- R6: `other_cmd_i` or `reset_cmd_i` during the window cancels it, returns the block to idle and drops the collected sectors.
- R7: When the window expires with at least one unprotected sector selected, `erase_go_o` pulses for one cycle with `erase_mask_o` = selected & ~protected. The erase then keeps `busy_o` high for T_ERASE cycles counted from that pulse, with bit 3 at 1 and bit 7 at 0. Afterwards bit 7 reads 1.
- R8: A program aimed at a protected sector does not fail. It stays busy for T_PFAKE cycles with bit 7 complemented, then returns to idle.
- R9: An erase whose selected sectors are all protected gives no `erase_go_o`. It stays busy for T_EFAKE cycles after the window, with bit 3 at 1.
- R10: Chip erase skips the window. In the next cycle `erase_go_o` is 1 with `erase_mask_o` = ~protected, and the erase lasts T_ERASE cycles. If every sector is protected, it becomes a T_EFAKE busy period with no pulse.
- R11: Every command arriving during a running program or erase is ignored, and the operation keeps its full duration.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| prog_start_i | input | 1 | Program start event |
| prog_sec_i | input | SW | Sector of the program target |
| prog_data_i | input | 8 | Byte to program |
| cell_data_i | input | 8 | Byte currently stored at the target |
| sec_erase_i | input | 1 | Sector erase command |
| erase_sec_i | input | SW | Sector named by the sector erase command |
| chip_erase_i | input | 1 | Chip erase command |
| other_cmd_i | input | 1 | Any other completed command |
| reset_cmd_i | input | 1 | Reset command |
| rd_i | input | 1 | Read strobe |
| prot_mask_i | input | NSEC | Per-sector protection, 1 = protected |
| status_o | output | 8 | Status byte (bits 7, 6, 5, 3 used, others 0) |
| busy_o | output | 1 | Operation or erase window active |
| erase_go_o | output | 1 | One-cycle erase-start event |
| erase_mask_o | output | NSEC | Sectors the erase acts on |

## Verification
The bench builds the block with eight sectors and durations of a few cycles: window 20, program 5, pulse limit 9, protected-program 7, protected-erase 13, erase 11. At these values every timeout, window restart and fake-busy period is reached within tens of cycles. Exact counts can therefore tell a restarted window from an unrestarted one, a real program from a protected one, and a failing program from a clean one. Random program bytes, stored bytes and protection masks mix all three program outcomes.

// File: rtl/flash_status_pkg.sv
package flash_status_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PROG,
    ST_WIN,
    ST_ERASE,
    ST_FAKE,
    ST_FAIL
  } fs_state_e;

  localparam int unsigned BIT_POLL = 7;
  localparam int unsigned BIT_TOG  = 6;
  localparam int unsigned BIT_FAIL = 5;
  localparam int unsigned BIT_WIN  = 3;

  function automatic int unsigned fs_max(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/fs_countdown.sv
module fs_countdown #(
  parameter int unsigned CW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [CW-1:0] load_val_i,
  input  logic          dec_i,
  output logic          last_o
);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  always_comb begin
    cnt_en = load_i || (dec_i && (cnt_q != '0));
    cnt_d  = load_i ? load_val_i : cnt_q - CW'(1);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign last_o = (cnt_q == CW'(1));

  AST_CNT_HOLD_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && cnt_q == '0) |=> (cnt_q == '0)); // R2

endmodule

// File: rtl/fs_sector_sel.sv
module fs_sector_sel #(
  parameter int unsigned NSEC = 8,
  parameter int unsigned SW   = $clog2(NSEC)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            clr_i,
  input  logic            all_i,
  input  logic            add_i,
  input  logic [SW-1:0]   add_sec_i,
  input  logic [NSEC-1:0] prot_i,
  output logic [NSEC-1:0] eff_o,
  output logic            none_o
);

  logic [NSEC-1:0] sel_q;

  for (genvar g = 0; g < NSEC; g++) begin : g_sec
    logic bit_q;
    logic bit_en;
    assign bit_en = clr_i || all_i || (add_i && (add_sec_i == SW'(g)));
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)     bit_q <= 1'b0;
      else if (bit_en) bit_q <= !clr_i;
    end
    assign sel_q[g] = bit_q;
  end

  assign eff_o  = sel_q & ~prot_i;
  assign none_o = (eff_o == '0);

  AST_SEL_CLEARED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (eff_o == '0)); // R6

endmodule

// File: rtl/flash_op_status.sv
module flash_op_status
  import flash_status_pkg::*;
#(
  parameter int unsigned NSEC    = 8,
  parameter int unsigned SW      = $clog2(NSEC),
  parameter int unsigned T_WIN   = 2500000,
  parameter int unsigned T_PFAKE = 100000,
  parameter int unsigned T_EFAKE = 5000000,
  parameter int unsigned T_PROG  = 350,
  parameter int unsigned T_ERASE = 50000000,
  parameter int unsigned T_PLIM  = 1000
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            prog_start_i,
  input  logic [SW-1:0]   prog_sec_i,
  input  logic [7:0]      prog_data_i,
  input  logic [7:0]      cell_data_i,
  input  logic            sec_erase_i,
  input  logic [SW-1:0]   erase_sec_i,
  input  logic            chip_erase_i,
  input  logic            other_cmd_i,
  input  logic            reset_cmd_i,
  input  logic            rd_i,
  input  logic [NSEC-1:0] prot_mask_i,
  output logic [7:0]      status_o,
  output logic            busy_o,
  output logic            erase_go_o,
  output logic [NSEC-1:0] erase_mask_o
);

  localparam int unsigned TMAX = fs_max(fs_max(fs_max(T_WIN, T_PFAKE), fs_max(T_EFAKE, T_PROG)),
                                        fs_max(T_ERASE, T_PLIM));
  localparam int unsigned CW   = $clog2(TMAX + 1);

  fs_state_e     st_q, st_d;
  logic          d7_q, d7_d, kind_q, kind_d, bad_q, bad_d, tog_q, go_q, go_d;
  logic          ld, tmr_last, tmr_dec, sel_clr, sel_all, sel_add, sel_none;
  logic [CW-1:0] ldv;

  fs_countdown #(.CW(CW)) u_tmr (
    .clk_i(clk_i), .rst_ni(rst_ni), .load_i(ld), .load_val_i(ldv),
    .dec_i(tmr_dec), .last_o(tmr_last)
  );

  fs_sector_sel #(.NSEC(NSEC), .SW(SW)) u_sel (
    .clk_i(clk_i), .rst_ni(rst_ni), .clr_i(sel_clr), .all_i(sel_all),
    .add_i(sel_add), .add_sec_i(erase_sec_i), .prot_i(prot_mask_i),
    .eff_o(erase_mask_o), .none_o(sel_none)
  );

  // next-state logic
  always_comb begin
    st_d    = st_q;
    d7_d    = d7_q;
    kind_d  = kind_q;
    bad_d   = bad_q;
    go_d    = 1'b0;
    ld      = 1'b0;
    ldv     = '0;
    sel_all = 1'b0;
    sel_add = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        if (prog_start_i) begin
          d7_d   = prog_data_i[7];
          kind_d = 1'b0;
          ld     = 1'b1;
          if (prot_mask_i[prog_sec_i]) begin
            st_d = ST_FAKE;
            ldv  = CW'(T_PFAKE);
          end else if ((prog_data_i & ~cell_data_i) != 8'h00) begin
            st_d  = ST_PROG;
            bad_d = 1'b1;
            ldv   = CW'(T_PLIM);
          end else begin
            st_d  = ST_PROG;
            bad_d = 1'b0;
            ldv   = CW'(T_PROG);
          end
        end else if (chip_erase_i) begin
          d7_d    = 1'b1;
          kind_d  = 1'b1;
          sel_all = 1'b1;
          ld      = 1'b1;
          if (&prot_mask_i) begin
            st_d = ST_FAKE;
            ldv  = CW'(T_EFAKE);
          end else begin
            st_d = ST_ERASE;
            ldv  = CW'(T_ERASE);
            go_d = 1'b1;
          end
        end else if (sec_erase_i) begin
          d7_d    = 1'b1;
          kind_d  = 1'b1;
          sel_add = 1'b1;
          ld      = 1'b1;
          ldv     = CW'(T_WIN);
          st_d    = ST_WIN;
        end
      end
      ST_PROG: if (tmr_last) st_d = bad_q ? ST_FAIL : ST_IDLE;
      ST_WIN: begin
        if (other_cmd_i || reset_cmd_i) begin
          st_d = ST_IDLE;
        end else if (sec_erase_i) begin
          sel_add = 1'b1;
          ld      = 1'b1;
          ldv     = CW'(T_WIN);
        end else if (tmr_last) begin
          ld = 1'b1;
          if (sel_none) begin
            st_d = ST_FAKE;
            ldv  = CW'(T_EFAKE);
          end else begin
            st_d = ST_ERASE;
            ldv  = CW'(T_ERASE);
            go_d = 1'b1;
          end
        end
      end
      ST_ERASE: if (tmr_last) st_d = ST_IDLE;
      ST_FAKE:  if (tmr_last) st_d = ST_IDLE;
      ST_FAIL:  if (reset_cmd_i) st_d = ST_IDLE;
      default:  st_d = ST_IDLE;
    endcase
    sel_clr = (st_d == ST_IDLE);
    tmr_dec = (st_q != ST_IDLE) && (st_q != ST_FAIL) && !ld;
  end

  // state registers
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      d7_q   <= 1'b1;
      kind_q <= 1'b0;
      bad_q  <= 1'b0;
      go_q   <= 1'b0;
    end else begin
      st_q   <= st_d;
      d7_q   <= d7_d;
      kind_q <= kind_d;
      bad_q  <= bad_d;
      go_q   <= go_d;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               tog_q <= 1'b0;
    else if (rd_i && busy_o)   tog_q <= !tog_q;
  end

  always_comb begin
    busy_o             = (st_q != ST_IDLE);
    erase_go_o         = go_q;
    status_o           = 8'h00;
    status_o[BIT_POLL] = (st_q == ST_IDLE) ? d7_q : !d7_q;
    status_o[BIT_TOG]  = tog_q;
    status_o[BIT_FAIL] = (st_q == ST_FAIL);
    status_o[BIT_WIN]  = kind_q && ((st_q == ST_ERASE) || (st_q == ST_FAKE));
  end

  AST_TOG_FLIP_ON_READ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && rd_i) |=> (status_o[BIT_TOG] != $past(status_o[BIT_TOG]))); // R3
  AST_TOG_FROZEN_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o) |=> $stable(status_o[BIT_TOG])); // R3
  AST_FAIL_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (status_o[BIT_FAIL] && !reset_cmd_i) |=> status_o[BIT_FAIL]); // R4
  AST_WIN_CANCEL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((st_q == ST_WIN) && (other_cmd_i || reset_cmd_i)) |=> !busy_o); // R6
  AST_GO_MASK_NONZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    erase_go_o |-> (erase_mask_o != '0)); // R7
  AST_GO_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    erase_go_o |=> !erase_go_o); // R7
  AST_PROG_KEEPS_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((st_q == ST_PROG) && !tmr_last) |=> busy_o); // R11

endmodule

// File: tb/tb_flash_op_status.sv
module tb_flash_op_status;

  localparam int unsigned NSEC = 8, SW = 3;
  localparam int unsigned T_WIN = 20, T_PFAKE = 7, T_EFAKE = 13;
  localparam int unsigned T_PROG = 5, T_ERASE = 11, T_PLIM = 9;

  logic clk = 1'b0, rst_n = 1'b0;
  logic prog_start = 0, sec_erase = 0, chip_erase = 0, other_cmd = 0, reset_cmd = 0, rd = 0;
  logic [SW-1:0] prog_sec = '0, erase_sec = '0;
  logic [7:0] prog_data = '0, cell_data = '0;
  logic [NSEC-1:0] prot = '0;
  logic [7:0] status;
  logic busy, erase_go;
  logic [NSEC-1:0] emask;
  int total = 0, bad = 0;

  always #10 clk = !clk;

  flash_op_status #(.NSEC(NSEC), .T_WIN(T_WIN), .T_PFAKE(T_PFAKE), .T_EFAKE(T_EFAKE),
    .T_PROG(T_PROG), .T_ERASE(T_ERASE), .T_PLIM(T_PLIM)) dut (
    .clk_i(clk), .rst_ni(rst_n), .prog_start_i(prog_start), .prog_sec_i(prog_sec),
    .prog_data_i(prog_data), .cell_data_i(cell_data), .sec_erase_i(sec_erase),
    .erase_sec_i(erase_sec), .chip_erase_i(chip_erase), .other_cmd_i(other_cmd),
    .reset_cmd_i(reset_cmd), .rd_i(rd), .prot_mask_i(prot), .status_o(status),
    .busy_o(busy), .erase_go_o(erase_go), .erase_mask_o(emask));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  // bench model: outcome of a program attempt (0 clean, 1 fail, 2 protected)
  function automatic int prog_kind(input logic [7:0] d, input logic [7:0] c, input logic p);
    if (p) return 2;
    if ((d & ~c) != 8'h00) return 1;
    return 0;
  endfunction

  function automatic int prog_len(input int k);
    return (k == 2) ? T_PFAKE : (k == 1) ? T_PLIM : T_PROG;
  endfunction

  task automatic end_pulse();
    @(negedge clk);
    prog_start = 0; sec_erase = 0; chip_erase = 0; other_cmd = 0; reset_cmd = 0; rd = 0;
  endtask

  task automatic do_prog(input logic [SW-1:0] s, input logic [7:0] d, input logic [7:0] c);
    prog_sec = s; prog_data = d; cell_data = c; prog_start = 1; end_pulse();
  endtask
  task automatic do_sec(input logic [SW-1:0] s);
    erase_sec = s; sec_erase = 1; end_pulse();
  endtask
  task automatic do_chip();   chip_erase = 1; end_pulse(); endtask
  task automatic do_other();  other_cmd = 1;  end_pulse(); endtask
  task automatic do_reset();  reset_cmd = 1;  end_pulse(); endtask
  task automatic do_read();   rd = 1;         end_pulse(); endtask

  task automatic wait_idle(output int n);
    n = 0;
    while (busy && n < 1000) begin n++; @(negedge clk); end
  endtask

  task automatic wait_go(output int n);
    n = 0;
    while (!erase_go && n < 1000) begin n++; @(negedge clk); end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL R11 watchdog act=running exp=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int n;
    logic t0;
    void'($urandom(32'h5eed_0042));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk("R1 busy", busy, 0);
    chk("R1 status", status, 8'h80);
    chk("R1 go", erase_go, 0);

    // R2 clean program, bit 7 of data = 0
    do_prog(3'd2, 8'h35, 8'hFF);
    chk("R2 busy", busy, 1);
    chk("R2 poll complement", status[7], 1);
    chk("R2 no fail bit", status[5], 0);
    wait_idle(n);
    chk("R2 duration", n, T_PROG);
    chk("R2 poll true", status[7], 0);
    t0 = status[6];
    do_read();
    chk("R3 idle toggle frozen", status[6], t0);

    // R2 bit 7 = 1, R3 toggling on reads
    do_prog(3'd1, 8'hA5, 8'hFF);
    chk("R2 poll complement 1", status[7], 0);
    for (int i = 0; i < 3; i++) begin
      t0 = status[6];
      do_read();
      chk("R3 toggle flips", status[6], !t0);
    end
    wait_idle(n);
    chk("R2 poll true 1", status[7], 1);

    // R4 program raising a 0 to 1
    do_prog(3'd0, 8'h0F, 8'hF0);
    n = 0;
    while (!status[5] && n < 1000) begin n++; @(negedge clk); end
    chk("R4 limit cycles", n, T_PLIM);
    do_other();
    do_prog(3'd0, 8'h00, 8'hFF);
    chk("R4 fail sticky", status[5], 1);
    chk("R4 still busy", busy, 1);
    do_reset();
    chk("R4 reset clears", {busy, status[5]}, 2'b00);

    // R8 protected program
    prot = 8'h08;
    do_prog(3'd3, 8'h00, 8'hFF);
    chk("R8 complement", status[7], 1);
    wait_idle(n);
    chk("R8 fake duration", n, T_PFAKE);
    chk("R8 no fail", status[5], 0);
    prot = '0;

    // R11 reset command during program ignored
    do_prog(3'd4, 8'h11, 8'hFF);
    do_reset();
    wait_idle(n);
    chk("R11 prog full length", n, T_PROG - 1);

    // R5/R7 window with restart
    do_sec(3'd1);
    chk("R5 window bits", {busy, status[7], status[3]}, 3'b100);
    repeat (5) @(negedge clk);
    do_sec(3'd4);
    wait_go(n);
    chk("R5 restart window", n, T_WIN);
    chk("R7 mask", emask, 8'h12);
    chk("R7 erase bits", {status[7], status[3]}, 2'b01);
    wait_idle(n);
    chk("R7 erase duration", n, T_ERASE);
    chk("R7 done bit7", status[7], 1);

    // R7 protected sector skipped, R3 toggle in window
    prot = 8'h02;
    do_sec(3'd1);
    t0 = status[6];
    do_read();
    chk("R3 window toggle", status[6], !t0);
    do_sec(3'd4);
    wait_go(n);
    chk("R7 skip protected", emask, 8'h10);
    @(negedge clk);
    chk("R7 single pulse", erase_go, 0);
    wait_idle(n);
    prot = '0;

    // R6 cancel
    do_sec(3'd5);
    do_other();
    chk("R6 cancel idle", busy, 0);
    do_sec(3'd6);
    wait_go(n);
    chk("R6 selection dropped", emask, 8'h40);
    wait_idle(n);

    // R9 all protected
    prot = 8'h01;
    do_sec(3'd0);
    begin
      int g = 0;
      logic b3 = 0;
      n = 0;
      while (busy && n < 1000) begin
        n++;
        if (erase_go) g++;
        if (n == T_WIN + 1) b3 = status[3];
        @(negedge clk);
      end
      chk("R9 duration", n, T_WIN + T_EFAKE);
      chk("R9 no go", g, 0);
      chk("R9 bit3", b3, 1);
    end

    // R10 chip erase, R11 command during erase
    prot = 8'h81;
    do_chip();
    chk("R10 go next cycle", erase_go, 1);
    chk("R10 mask", emask, 8'h7E);
    chk("R10 bit3", status[3], 1);
    do_other();
    wait_idle(n);
    chk("R11 erase full length", n, T_ERASE - 1);
    prot = 8'hFF;
    do_chip();
    chk("R10 protected no go", erase_go, 0);
    wait_idle(n);
    chk("R10 fake duration", n, T_EFAKE);
    prot = '0;

    // random program mix (R2, R4, R8)
    for (int it = 0; it < 24; it++) begin
      logic [7:0] d, c;
      logic [SW-1:0] s;
      int k;
      d = 8'($urandom); c = 8'($urandom | $urandom);
      s = SW'($urandom);
      prot = NSEC'($urandom & $urandom);
      k = prog_kind(d, c, prot[s]);
      do_prog(s, d, c);
      chk("R2 rand poll", status[7], !d[7]);
      n = 0;
      while (busy && !status[5] && n < 1000) begin n++; @(negedge clk); end
      chk("R2 rand length", n, prog_len(k));
      chk("R4 rand fail bit", status[5], (k == 1));
      if (k == 1) do_reset();
      chk("R8 rand idle bit7", {busy, status[7]}, {1'b0, d[7]});
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule